// File: doc/BRIEF.md
# MAC Port Mode Control Register

This block holds the 32-bit read/write mode word for one Ethernet MAC port and works out the operating mode the port actually runs in. Software writes the word through a plain register-bus port, a single-cycle write strobe with a data word, and reads it back on a read-data bus that always shows the stored value. The MAC datapath, which is not part of this block, consumes the resolved outputs.

The effective duplex and speed come from register bits or from external status pins, selected by an external-control bit. A gigabit force bit, gigabit mode itself and loopback can each override duplex. The two flow-control enables can each be taken from a pin instead of the register. The word also holds the GMII datapath out of reset, picks the CRC polynomial, drives two general-purpose interface-control pins, and opens write access to the test registers that sit beside it.

Top module: `mac_mode_ctrl`

## Requirements
- R1: A cycle with `wr_en` high stores `wdata` into the writable bits, and `rdata` shows the new value from the next clock edge on. Without `wr_en` the stored word does not change.
- R2: Bits 8, 9, 13, 14 and 25 to 31 are reserved. They read as zero whatever is written, so the writable mask is 32'h01FF_9CFF.
- R3: After reset the stored word is zero. The resolved outputs are then fdx_eff=0, gig_eff=0 (with pins low), gmii_rst=1 and test_wr_ok=0.
- R4: With bit 18 (external control) set, the selected duplex and speed come from `ext_fdx` and `ext_gig`. With bit 18 clear they come from bit 0 and bit 7.
- R5: `gig_eff` is the selected speed ORed with bit 17 (gigabit force). Whenever `gig_eff` is 1, `fdx_eff` is 1.
- R6: Bit 1 (loopback) drives `loopback` and forces `fdx_eff` to 1. Otherwise `fdx_eff` is the selected duplex ORed with `gig_eff`.
- R7: `rxfc_eff` is `ext_rxfc` when bit 19 is set and bit 3 otherwise. `txfc_eff` is `ext_txfc` when bit 20 is set and bit 4 otherwise.
- R8: `gmii_rst` is 1 while bit 5 (GMII enable) is 0.
- R9: `test_wr_ok` equals bit 2, the manufacturing test bit.
- R10: `fdx_cfg` follows bit 0 and `gig_cfg` follows bit 7, whatever the pin and force settings.
- R11: `crc_sel` follows bit 12, `ifc_a` follows bit 15 and `ifc_b` follows bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Stored mode word |
| ext_fdx | input | 1 | External full-duplex status |
| ext_gig | input | 1 | External gigabit status |
| ext_rxfc | input | 1 | External receive flow-control enable |
| ext_txfc | input | 1 | External transmit flow-control enable |
| fdx_eff | output | 1 | Effective full duplex |
| gig_eff | output | 1 | Effective gigabit mode |
| rxfc_eff | output | 1 | Effective receive flow-control enable |
| txfc_eff | output | 1 | Effective transmit flow-control enable |
| fdx_cfg | output | 1 | Raw full-duplex bit |
| gig_cfg | output | 1 | Raw gigabit bit |
| gmii_rst | output | 1 | Holds the GMII rx/tx datapath in reset |
| loopback | output | 1 | Loopback mode |
| crc_sel | output | 1 | CRC type: 0 Ethernet, 1 Castagnoli |
| ifc_a | output | 1 | Interface control output A |
| ifc_b | output | 1 | Interface control output B |
| test_wr_ok | output | 1 | Write permission for the test registers |

## Verification
A write lands one clock edge after the strobe cycle. The bench holds `wr_en` for one cycle starting at a falling edge and samples `rdata` at the following falling edge, after exactly one rising edge. Every resolved output is combinational from the stored word and the pins. The bench therefore changes the pins only after the write has landed, waits one time unit, and then compares the outputs against values it works out itself. These comparisons run over every combination of the mode-relevant bits and pins.

// File: rtl/mac_mode_ctrl.sv
module mac_mode_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        ext_fdx,
  input  logic        ext_gig,
  input  logic        ext_rxfc,
  input  logic        ext_txfc,
  output logic        fdx_eff,
  output logic        gig_eff,
  output logic        rxfc_eff,
  output logic        txfc_eff,
  output logic        fdx_cfg,
  output logic        gig_cfg,
  output logic        gmii_rst,
  output logic        loopback,
  output logic        crc_sel,
  output logic        ifc_a,
  output logic        ifc_b,
  output logic        test_wr_ok
);
  localparam logic [31:0] WMASK = 32'h01FF_9CFF;
  localparam int B_FDX = 0, B_LPBK = 1, B_TEST = 2, B_RXFC = 3, B_TXFC = 4,
                 B_GMII = 5, B_GIG = 7, B_CRC = 12, B_IFA = 15, B_IFB = 16,
                 B_GFRC = 17, B_EXT = 18, B_XRX = 19, B_XTX = 20;

  logic [31:0] ctrl_q;
  logic        sel_fdx, sel_gig;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & WMASK;

  assign rdata      = ctrl_q;
  assign sel_fdx    = ctrl_q[B_EXT] ? ext_fdx : ctrl_q[B_FDX];
  assign sel_gig    = ctrl_q[B_EXT] ? ext_gig : ctrl_q[B_GIG];
  assign gig_eff    = sel_gig | ctrl_q[B_GFRC];
  assign fdx_eff    = sel_fdx | gig_eff | ctrl_q[B_LPBK];
  assign rxfc_eff   = ctrl_q[B_XRX] ? ext_rxfc : ctrl_q[B_RXFC];
  assign txfc_eff   = ctrl_q[B_XTX] ? ext_txfc : ctrl_q[B_TXFC];
  assign fdx_cfg    = ctrl_q[B_FDX];
  assign gig_cfg    = ctrl_q[B_GIG];
  assign gmii_rst   = ~ctrl_q[B_GMII];
  assign loopback   = ctrl_q[B_LPBK];
  assign crc_sel    = ctrl_q[B_CRC];
  assign ifc_a      = ctrl_q[B_IFA];
  assign ifc_b      = ctrl_q[B_IFB];
  assign test_wr_ok = ctrl_q[B_TEST];
endmodule

module mac_mode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        ext_gig,
  input logic        fdx_eff,
  input logic        gig_eff,
  input logic        gmii_rst,
  input logic        loopback,
  input logic        test_wr_ok
);
  p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata == ($past(wdata) & 32'h01FF_9CFF));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rdata));
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~32'h01FF_9CFF) == 32'h0);
  p_ext_gig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[18] |-> gig_eff == (ext_gig | rdata[17]));
  p_gig_fdx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gig_eff |-> fdx_eff);
  p_lpbk_fdx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> fdx_eff);
  p_gmii_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[5] |-> gmii_rst);
  p_test_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    test_wr_ok |-> rdata[2]);
endmodule

bind mac_mode_ctrl mac_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .ext_gig(ext_gig), .fdx_eff(fdx_eff), .gig_eff(gig_eff),
  .gmii_rst(gmii_rst), .loopback(loopback), .test_wr_ok(test_wr_ok)
);

// File: tb/mac_mode_ctrl_bench.sv
module mac_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXP_MASK = 32'h01FF_9CFF;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wdata = '0, rdata;
  logic ext_fdx = 0, ext_gig = 0, ext_rxfc = 0, ext_txfc = 0;
  logic fdx_eff, gig_eff, rxfc_eff, txfc_eff, fdx_cfg, gig_cfg;
  logic gmii_rst, loopback, crc_sel, ifc_a, ifc_b, test_wr_ok;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_mode_ctrl u_mac_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .ext_fdx(ext_fdx), .ext_gig(ext_gig), .ext_rxfc(ext_rxfc), .ext_txfc(ext_txfc),
    .fdx_eff(fdx_eff), .gig_eff(gig_eff), .rxfc_eff(rxfc_eff), .txfc_eff(txfc_eff),
    .fdx_cfg(fdx_cfg), .gig_cfg(gig_cfg), .gmii_rst(gmii_rst), .loopback(loopback),
    .crc_sel(crc_sel), .ifc_a(ifc_a), .ifc_b(ifc_b), .test_wr_ok(test_wr_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write(input logic [31:0] v);
    @(negedge clk); wr_en = 1; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R3 rdata", rdata, 0);
    check("R3 gmii_rst", {31'b0, gmii_rst}, 1);
    check("R3 fdx_eff", {31'b0, fdx_eff}, 0);
    check("R3 gig_eff", {31'b0, gig_eff}, 0);
    check("R3 test_wr_ok", {31'b0, test_wr_ok}, 0);
    rst_n = 1;

    for (int i = 0; i < 32; i++) begin
      write(32'h1 << i);
      check("R1/R2 walking bit", rdata, (32'h1 << i) & EXP_MASK);
    end
    write(32'hFFFF_FFFF);
    check("R2 all ones", rdata, EXP_MASK);
    write(32'h0000_1234);
    wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R1 hold without strobe", rdata, 32'h0000_1234 & EXP_MASK);

    for (int v = 0; v < 128; v++) begin
      logic f, lb, g, frc, ext, pf, pg, sg, sf, ge, fe;
      f = v[0]; lb = v[1]; g = v[2]; frc = v[3]; ext = v[4]; pf = v[5]; pg = v[6];
      write((32'(f) << 0) | (32'(lb) << 1) | (32'(g) << 7) | (32'(frc) << 17) | (32'(ext) << 18));
      ext_fdx = pf; ext_gig = pg;
      #1;
      sg = ext ? pg : g;
      sf = ext ? pf : f;
      ge = sg | frc;
      fe = sf | ge | lb;
      check("R4/R5 gig_eff", {31'b0, gig_eff}, {31'b0, ge});
      check("R4/R5/R6 fdx_eff", {31'b0, fdx_eff}, {31'b0, fe});
      check("R6 loopback", {31'b0, loopback}, {31'b0, lb});
      check("R10 fdx_cfg", {31'b0, fdx_cfg}, {31'b0, f});
      check("R10 gig_cfg", {31'b0, gig_cfg}, {31'b0, g});
    end

    for (int v = 0; v < 64; v++) begin
      logic rb, tb, xr, xt, pr, pt;
      rb = v[0]; tb = v[1]; xr = v[2]; xt = v[3]; pr = v[4]; pt = v[5];
      write((32'(rb) << 3) | (32'(tb) << 4) | (32'(xr) << 19) | (32'(xt) << 20));
      ext_rxfc = pr; ext_txfc = pt;
      #1;
      check("R7 rxfc_eff", {31'b0, rxfc_eff}, {31'b0, xr ? pr : rb});
      check("R7 txfc_eff", {31'b0, txfc_eff}, {31'b0, xt ? pt : tb});
    end

    for (int v = 0; v < 32; v++) begin
      write((32'(v[0]) << 2) | (32'(v[1]) << 5) | (32'(v[2]) << 12) |
            (32'(v[3]) << 15) | (32'(v[4]) << 16));
      check("R9 test_wr_ok", {31'b0, test_wr_ok}, {31'b0, v[0]});
      check("R8 gmii_rst", {31'b0, gmii_rst}, {31'b0, ~v[1]});
      check("R11 crc_sel", {31'b0, crc_sel}, {31'b0, v[2]});
      check("R11 ifc_a", {31'b0, ifc_a}, {31'b0, v[3]});
      check("R11 ifc_b", {31'b0, ifc_b}, {31'b0, v[4]});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule